// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block holds the tags and data of a direct-mapped cache. Next to the main array sits a small fully associative store of lines that the main array has recently pushed out. A requester presents one word-wide read or write at a time. A hit in the main array answers on the following cycle. A miss in the main array that finds the line in the side store exchanges the two lines: the side-store line enters the main array and the displaced main line takes over the freed side-store slot. No next-level traffic occurs in that case. When neither structure holds the line, the block fetches the whole line from the next memory level. It then moves the displaced main line into a side-store slot. An empty slot is used if there is one. Otherwise the least recently inserted slot is used, and if that slot is dirty it is written back first.

The number of side-store entries is a parameter. The design also works with a single entry, where it keeps one recently displaced line per cache and still avoids one refill per conflict pair. Writes only ever modify the main array. A write that finds its line in the side store is applied after the exchange. Dirty state moves with the line on every exchange, so modified data is never dropped.

Top module: `victim_dm_cache`

## Requirements
- R1: A request that hits the main array returns `resp_valid` exactly one cycle after the accepting clock edge and causes no refill or writeback.
- R2: A request that misses both structures raises `mem_rd_req` with the line address (request address without the word offset) and holds both until `mem_rd_valid`. The response follows in the cycle after the refill data is taken.
- R3: A valid main-array line displaced by a refill is kept in the side store and can later be hit there without a refill.
- R4: A side-store hit exchanges the line with the main-array line at the same index. It responds two cycles after acceptance and causes no refill.
- R5: On insertion, an empty side-store slot is chosen first. Otherwise the slot least recently filled or exchanged into is replaced.
- R6: A replaced side-store slot that is dirty is written back first, with its line address and full line data, and this completes before the refill request. A clean replaced slot leaves without any writeback.
- R7: Dirty state follows a line through every exchange and eviction, so each read returns the last value written to that word.
- R8: A write whose line sits in the side store is applied to the main array after the exchange. A following read of that word is a main-array hit returning the new value.
- R9: `req_ready` is high only while the block is idle. After reset it is high, and `resp_valid`, `mem_rd_req` and `mem_wb_valid` are low. `resp_valid` is a single-cycle pulse.
- R10: Address layout, from the least significant bit upward: the word offset within the line, then the set index, then the tag. Word k of a line occupies data bits [k*DATA_W +: DATA_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and takes the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | DATA_W | Word read, or the word written |
| mem_rd_req | output | 1 | Line refill request |
| mem_rd_addr | output | ADDR_W-OFF_W | Line address to refill |
| mem_rd_valid | input | 1 | Refill data present |
| mem_rd_data | input | LINE_W | Refill line |
| mem_wb_valid | output | 1 | Writeback line present |
| mem_wb_ready | input | 1 | Next level takes the writeback |
| mem_wb_addr | output | ADDR_W-OFF_W | Line address written back |
| mem_wb_data | output | LINE_W | Line written back |

## Verification
The assertions assume that the next level raises `mem_rd_valid` only while a refill is requested and `mem_wb_ready` only while a writeback is offered. They also assume requests are offered only when `req_ready` is high. The bench memory model answers only pending transfers, after fixed delays, and it sends a new request only after the previous response. The stimulus uses four tags over four sets, which forces conflicts, exchanges and dirty evictions in both directed runs and a random sweep. A flat reference memory predicts every read.

// File: rtl/cvb_pkg.sv
package cvb_pkg;

    parameter int CVB_ADDR_W     = 8;
    parameter int CVB_DATA_W     = 8;
    parameter int CVB_LINE_WORDS = 2;
    parameter int CVB_SETS       = 4;
    parameter int CVB_VICT_N     = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_SWAP,
        ST_WB,
        ST_FILL
    } ctl_state_e;

    // index width that never collapses to zero bits
    function automatic int width_of(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/cvb_main_store.sv
module cvb_main_store #(
    parameter int SETS   = cvb_pkg::CVB_SETS,
    parameter int TAG_W  = 4,
    parameter int LINE_W = 16,
    localparam int IDX_W = cvb_pkg::width_of(SETS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [LINE_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic              wr_dirty,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_data
);

    typedef struct packed {
        logic              valid;
        logic              dirty;
        logic [TAG_W-1:0]  tag;
    } meta_t;

    meta_t             meta_q [SETS];
    logic [LINE_W-1:0] data_q [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                meta_q[s] <= '0;
            end
        end else if (wr_en) begin
            meta_q[wr_idx] <= '{valid: wr_valid, dirty: wr_valid & wr_dirty, tag: wr_tag};
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            data_q[wr_idx] <= wr_data;
        end
    end

    always_comb begin
        rd_valid = meta_q[rd_idx].valid;
        rd_dirty = meta_q[rd_idx].dirty;
        rd_tag   = meta_q[rd_idx].tag;
        rd_data  = data_q[rd_idx];
    end

    // R7: a clean set never reports dirty
    clean_not_dirty_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> !rd_dirty);

endmodule

// File: rtl/cvb_victim_buf.sv
module cvb_victim_buf #(
    parameter int ENTRIES = cvb_pkg::CVB_VICT_N,
    parameter int LADDR_W = 7,
    parameter int LINE_W  = 16,
    localparam int SLOT_W = cvb_pkg::width_of(ENTRIES),
    localparam int AGE_W  = cvb_pkg::width_of(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    // associative lookup
    input  logic [LADDR_W-1:0] lk_laddr,
    output logic               lk_hit,
    output logic [SLOT_W-1:0]  lk_slot,
    // slot chosen for the next insertion
    output logic [SLOT_W-1:0]  alloc_slot,
    // read of one slot
    input  logic [SLOT_W-1:0]  sel_slot,
    output logic               sel_valid,
    output logic               sel_dirty,
    output logic [LADDR_W-1:0] sel_laddr,
    output logic [LINE_W-1:0]  sel_data,
    // write of one slot, also marks it most recent when valid
    input  logic               wr_en,
    input  logic [SLOT_W-1:0]  wr_slot,
    input  logic               wr_valid,
    input  logic               wr_dirty,
    input  logic [LADDR_W-1:0] wr_laddr,
    input  logic [LINE_W-1:0]  wr_data
);

    logic               valid_q [ENTRIES];
    logic               dirty_q [ENTRIES];
    logic [LADDR_W-1:0] laddr_q [ENTRIES];
    logic [LINE_W-1:0]  data_q  [ENTRIES];
    logic [AGE_W-1:0]   age_q   [ENTRIES];
    logic [ENTRIES-1:0] hit_vec;

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
            assign hit_vec[g] = valid_q[g] && (laddr_q[g] == lk_laddr);
        end
    endgenerate

    always_comb begin
        lk_hit  = |hit_vec;
        lk_slot = '0;
        for (int j = 0; j < ENTRIES; j++) begin
            if (hit_vec[j]) begin
                lk_slot = SLOT_W'(j);
            end
        end
    end

    // oldest slot, overridden by the lowest empty slot
    always_comb begin
        logic found_empty;
        found_empty = 1'b0;
        alloc_slot  = '0;
        for (int j = 0; j < ENTRIES; j++) begin
            if (age_q[j] == AGE_W'(ENTRIES - 1)) begin
                alloc_slot = SLOT_W'(j);
            end
        end
        for (int j = 0; j < ENTRIES; j++) begin
            if (!valid_q[j] && !found_empty) begin
                alloc_slot  = SLOT_W'(j);
                found_empty = 1'b1;
            end
        end
    end

    always_comb begin
        sel_valid = valid_q[sel_slot];
        sel_dirty = dirty_q[sel_slot];
        sel_laddr = laddr_q[sel_slot];
        sel_data  = data_q[sel_slot];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < ENTRIES; j++) begin
                valid_q[j] <= 1'b0;
                dirty_q[j] <= 1'b0;
                age_q[j]   <= AGE_W'(j);
            end
        end else if (wr_en) begin
            valid_q[wr_slot] <= wr_valid;
            dirty_q[wr_slot] <= wr_valid & wr_dirty;
            if (wr_valid) begin
                for (int j = 0; j < ENTRIES; j++) begin
                    if (SLOT_W'(j) == wr_slot) begin
                        age_q[j] <= '0;
                    end else if (age_q[j] < age_q[wr_slot]) begin
                        age_q[j] <= age_q[j] + 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            laddr_q[wr_slot] <= wr_laddr;
            data_q[wr_slot]  <= wr_data;
        end
    end

    // R3: a line is never held twice
    single_hit_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    // R5: a freshly inserted line becomes the youngest
    touch_young_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_valid) |=> (age_q[$past(wr_slot)] == '0));

    // R5: a full slot is only chosen when it is the oldest
    alloc_oldest_chk: assert property (@(posedge clk) disable iff (rst)
        valid_q[alloc_slot] |-> (age_q[alloc_slot] == AGE_W'(ENTRIES - 1)));

endmodule

// File: rtl/victim_dm_cache.sv
module victim_dm_cache #(
    parameter int ADDR_W     = cvb_pkg::CVB_ADDR_W,
    parameter int DATA_W     = cvb_pkg::CVB_DATA_W,
    parameter int LINE_WORDS = cvb_pkg::CVB_LINE_WORDS,
    parameter int SETS       = cvb_pkg::CVB_SETS,
    parameter int VICT_N     = cvb_pkg::CVB_VICT_N,
    localparam int OFF_W     = cvb_pkg::width_of(LINE_WORDS),
    localparam int IDX_W     = cvb_pkg::width_of(SETS),
    localparam int LADDR_W   = ADDR_W - OFF_W,
    localparam int TAG_W     = LADDR_W - IDX_W,
    localparam int LINE_W    = LINE_WORDS * DATA_W,
    localparam int SLOT_W    = cvb_pkg::width_of(VICT_N)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               resp_valid,
    output logic [DATA_W-1:0]  resp_rdata,
    output logic               mem_rd_req,
    output logic [LADDR_W-1:0] mem_rd_addr,
    input  logic               mem_rd_valid,
    input  logic [LINE_W-1:0]  mem_rd_data,
    output logic               mem_wb_valid,
    input  logic               mem_wb_ready,
    output logic [LADDR_W-1:0] mem_wb_addr,
    output logic [LINE_W-1:0]  mem_wb_data
);
    import cvb_pkg::*;

    ctl_state_e         st;
    logic               q_write;
    logic [ADDR_W-1:0]  q_addr;
    logic [DATA_W-1:0]  q_wdata;
    logic [SLOT_W-1:0]  q_slot;

    logic [OFF_W-1:0]   q_off;
    logic [LADDR_W-1:0] q_laddr;
    logic [IDX_W-1:0]   q_idx;
    logic [TAG_W-1:0]   q_tag;

    assign q_off   = q_addr[OFF_W-1:0];
    assign q_laddr = q_addr[ADDR_W-1:OFF_W];
    assign q_idx   = q_laddr[IDX_W-1:0];
    assign q_tag   = q_laddr[LADDR_W-1:IDX_W];

    // main array ports
    logic              m_valid, m_dirty;
    logic [TAG_W-1:0]  m_tag;
    logic [LINE_W-1:0] m_data;
    logic              m_wr_en, m_wr_valid, m_wr_dirty;
    logic [TAG_W-1:0]  m_wr_tag;
    logic [LINE_W-1:0] m_wr_data;

    // side store ports
    logic               v_hit;
    logic [SLOT_W-1:0]  v_hit_slot, v_alloc, v_sel;
    logic               v_sel_valid, v_sel_dirty;
    logic [LADDR_W-1:0] v_sel_laddr;
    logic [LINE_W-1:0]  v_sel_data;
    logic               v_wr_en, v_wr_valid, v_wr_dirty;
    logic [LADDR_W-1:0] v_wr_laddr;
    logic [LINE_W-1:0]  v_wr_data;

    logic              main_hit;
    logic              finish;
    logic [LINE_W-1:0] merge_src;
    logic [LINE_W-1:0] merged;
    logic [DATA_W-1:0] word_out;

    cvb_main_store #(
        .SETS   (SETS),
        .TAG_W  (TAG_W),
        .LINE_W (LINE_W)
    ) u_main (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (q_idx),
        .rd_valid (m_valid),
        .rd_dirty (m_dirty),
        .rd_tag   (m_tag),
        .rd_data  (m_data),
        .wr_en    (m_wr_en),
        .wr_idx   (q_idx),
        .wr_valid (m_wr_valid),
        .wr_dirty (m_wr_dirty),
        .wr_tag   (m_wr_tag),
        .wr_data  (m_wr_data)
    );

    assign v_sel = (st == ST_LOOK) ? v_alloc : q_slot;

    cvb_victim_buf #(
        .ENTRIES (VICT_N),
        .LADDR_W (LADDR_W),
        .LINE_W  (LINE_W)
    ) u_vict (
        .clk        (clk),
        .rst        (rst),
        .lk_laddr   (q_laddr),
        .lk_hit     (v_hit),
        .lk_slot    (v_hit_slot),
        .alloc_slot (v_alloc),
        .sel_slot   (v_sel),
        .sel_valid  (v_sel_valid),
        .sel_dirty  (v_sel_dirty),
        .sel_laddr  (v_sel_laddr),
        .sel_data   (v_sel_data),
        .wr_en      (v_wr_en),
        .wr_slot    (q_slot),
        .wr_valid   (v_wr_valid),
        .wr_dirty   (v_wr_dirty),
        .wr_laddr   (v_wr_laddr),
        .wr_data    (v_wr_data)
    );

    assign main_hit = m_valid && (m_tag == q_tag);

    // line that the current access lands in, with the write merged
    always_comb begin
        unique case (st)
            ST_SWAP: merge_src = v_sel_data;
            ST_FILL: merge_src = mem_rd_data;
            default: merge_src = m_data;
        endcase
        merged = merge_src;
        if (q_write) begin
            merged[q_off*DATA_W +: DATA_W] = q_wdata;
        end
        word_out = merged[q_off*DATA_W +: DATA_W];
    end

    always_comb begin
        m_wr_en    = 1'b0;
        m_wr_valid = 1'b1;
        m_wr_dirty = 1'b0;
        m_wr_tag   = q_tag;
        m_wr_data  = merged;
        v_wr_en    = 1'b0;
        v_wr_valid = m_valid;
        v_wr_dirty = m_dirty;
        v_wr_laddr = {m_tag, q_idx};
        v_wr_data  = m_data;
        finish     = 1'b0;
        unique case (st)
            ST_LOOK: begin
                if (main_hit) begin
                    m_wr_en    = q_write;
                    m_wr_dirty = 1'b1;
                    finish     = 1'b1;
                end
            end
            ST_SWAP: begin
                m_wr_en    = 1'b1;
                m_wr_valid = v_sel_valid;
                m_wr_dirty = v_sel_dirty | q_write;
                m_wr_tag   = v_sel_laddr[LADDR_W-1:IDX_W];
                v_wr_en    = 1'b1;
                finish     = 1'b1;
            end
            ST_FILL: begin
                if (mem_rd_valid) begin
                    m_wr_en    = 1'b1;
                    m_wr_dirty = q_write;
                    v_wr_en    = m_valid;
                    finish     = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            q_write    <= 1'b0;
            q_addr     <= '0;
            q_wdata    <= '0;
            q_slot     <= '0;
            resp_valid <= 1'b0;
            resp_rdata <= '0;
        end else begin
            resp_valid <= finish;
            if (finish) begin
                resp_rdata <= word_out;
            end
            unique case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        q_write <= req_write;
                        q_addr  <= req_addr;
                        q_wdata <= req_wdata;
                        st      <= ST_LOOK;
                    end
                end
                ST_LOOK: begin
                    if (main_hit) begin
                        st <= ST_IDLE;
                    end else if (v_hit) begin
                        q_slot <= v_hit_slot;
                        st     <= ST_SWAP;
                    end else begin
                        q_slot <= v_alloc;
                        st     <= (m_valid && v_sel_valid && v_sel_dirty) ? ST_WB : ST_FILL;
                    end
                end
                ST_SWAP: st <= ST_IDLE;
                ST_WB:   if (mem_wb_ready) st <= ST_FILL;
                ST_FILL: if (mem_rd_valid) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign req_ready    = (st == ST_IDLE);
    assign mem_rd_req   = (st == ST_FILL);
    assign mem_rd_addr  = q_laddr;
    assign mem_wb_valid = (st == ST_WB);
    assign mem_wb_addr  = v_sel_laddr;
    assign mem_wb_data  = v_sel_data;

    // R1: an accepted request causes no next-level traffic in the following cycle
    quiet_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (!mem_rd_req && !mem_wb_valid));

    // R2: refill request and address stay put until data arrives
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

    // R6: writeback line stays put until taken
    wb_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wb_valid && !mem_wb_ready) |=> (mem_wb_valid && $stable(mem_wb_addr) && $stable(mem_wb_data)));

    // R6: writeback and refill never overlap
    wb_rd_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_wb_valid && mem_rd_req));

    // R9: a response is a single pulse
    resp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);

endmodule

// File: tb/tb_victim_dm_cache.sv
module tb_victim_dm_cache;

    localparam int CLK_P   = 10;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 8;
    localparam int LADDR_W = 7;
    localparam int LINE_W  = 16;
    localparam int NWORDS  = 256;
    localparam int NLINES  = 128;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              resp_valid;
    logic [DATA_W-1:0] resp_rdata;
    logic              mem_rd_req;
    logic [LADDR_W-1:0] mem_rd_addr;
    logic              mem_rd_valid = 1'b0;
    logic [LINE_W-1:0] mem_rd_data = '0;
    logic              mem_wb_valid;
    logic              mem_wb_ready = 1'b0;
    logic [LADDR_W-1:0] mem_wb_addr;
    logic [LINE_W-1:0] mem_wb_data;

    victim_dm_cache dut (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_write    (req_write),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .resp_valid   (resp_valid),
        .resp_rdata   (resp_rdata),
        .mem_rd_req   (mem_rd_req),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_data  (mem_rd_data),
        .mem_wb_valid (mem_wb_valid),
        .mem_wb_ready (mem_wb_ready),
        .mem_wb_addr  (mem_wb_addr),
        .mem_wb_data  (mem_wb_data)
    );

    always #(CLK_P/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    logic done = 1'b0;

    logic [LINE_W-1:0] backing [NLINES];
    logic [DATA_W-1:0] ref_mem [NWORDS];
    int refills = 0;
    int wbacks  = 0;
    int last_rd_addr = -1;
    int last_wb_addr = -1;
    logic [LINE_W-1:0] last_wb_data = '0;
    int rd_dly = 0;
    int wb_dly = 0;

    function automatic logic [DATA_W-1:0] init_word(input int w);
        return DATA_W'((w * 7 + 3) & 8'hFF);
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // next-level memory: refill after 3 cycles, writeback taken after 2
    always @(negedge clk) begin
        if (mem_rd_valid) begin
            mem_rd_valid = 1'b0;
        end else if (mem_rd_req) begin
            rd_dly++;
            if (rd_dly >= 3) begin
                rd_dly = 0;
                mem_rd_data  = backing[mem_rd_addr];
                mem_rd_valid = 1'b1;
                refills++;
                last_rd_addr = int'(mem_rd_addr);
            end
        end
        if (mem_wb_ready) begin
            mem_wb_ready = 1'b0;
        end else if (mem_wb_valid) begin
            wb_dly++;
            if (wb_dly >= 2) begin
                wb_dly = 0;
                backing[mem_wb_addr] = mem_wb_data;
                wbacks++;
                last_wb_addr = int'(mem_wb_addr);
                last_wb_data = mem_wb_data;
                mem_wb_ready = 1'b1;
            end
        end
    end

    task automatic do_req(input logic wr, input int addr, input int wd, output int rd, output int lat);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = ADDR_W'(addr);
        req_wdata = DATA_W'(wd);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (!resp_valid && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        rd = int'(resp_rdata);
        if (wr) ref_mem[addr] = DATA_W'(wd);
    endtask

    initial begin
        int rd, lat, rf0, wb0;
        for (int l = 0; l < NLINES; l++) begin
            backing[l] = {init_word(2*l + 1), init_word(2*l)};
        end
        for (int w = 0; w < NWORDS; w++) ref_mem[w] = init_word(w);

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check(req_ready == 1'b1, "R9 ready after reset", int'(req_ready), 1);
        check(resp_valid == 1'b0, "R9 resp idle after reset", int'(resp_valid), 0);
        check(!mem_rd_req && !mem_wb_valid, "R9 next level idle after reset",
              int'(mem_rd_req) + int'(mem_wb_valid), 0);

        // R2 cold miss on line 0 (tag0 idx0)
        rf0 = refills;
        do_req(1'b0, 0, 0, rd, lat);
        check(refills == rf0 + 1, "R2 refill count", refills - rf0, 1);
        check(last_rd_addr == 0, "R2 refill line address", last_rd_addr, 0);
        check(rd == int'(init_word(0)), "R10 word0 of refilled line", rd, int'(init_word(0)));

        // R1 main hit read and write
        rf0 = refills;
        do_req(1'b0, 1, 0, rd, lat);
        check(lat == 1, "R1 main hit latency", lat, 1);
        check(rd == int'(init_word(1)), "R10 word1 position", rd, int'(init_word(1)));
        do_req(1'b1, 1, 8'h5A, rd, lat);
        check(lat == 1, "R1 write hit latency", lat, 1);
        check(refills == rf0, "R1 no refill on hits", refills - rf0, 0);

        // R3 line 4 (tag1 idx0) displaces line 0 into the side store
        do_req(1'b0, 8, 0, rd, lat);
        check(rd == int'(init_word(8)), "R2 data of line 4", rd, int'(init_word(8)));
        rf0 = refills;
        do_req(1'b0, 1, 0, rd, lat);
        check(lat == 2, "R4 side-store hit latency", lat, 2);
        check(rd == 8'h5A, "R7 dirty word kept through displacement", rd, 8'h5A);
        do_req(1'b0, 8, 0, rd, lat);
        check(lat == 2, "R4 swap back latency", lat, 2);
        check(refills == rf0, "R3 no refill on side-store hits", refills - rf0, 0);

        // R5 line 8 fills the empty slot: no writeback of dirty line 0
        wb0 = wbacks;
        do_req(1'b0, 16, 0, rd, lat);
        check(wbacks == wb0, "R5 empty slot used first", wbacks - wb0, 0);
        // R6 line 12 evicts oldest (line 0, dirty)
        do_req(1'b0, 24, 0, rd, lat);
        check(wbacks == wb0 + 1, "R6 dirty eviction writes back", wbacks - wb0, 1);
        check(last_wb_addr == 0, "R5 oldest slot replaced", last_wb_addr, 0);
        check(last_wb_data[15:8] == 8'h5A, "R6 written-back data", int'(last_wb_data[15:8]), 8'h5A);
        // R6 line 16 evicts clean line 4: silent
        do_req(1'b0, 32, 0, rd, lat);
        check(wbacks == wb0 + 1, "R6 clean eviction silent", wbacks - wb0, 1);
        // R7 line 0 comes back from memory with its written word
        do_req(1'b0, 1, 0, rd, lat);
        check(last_rd_addr == 0, "R2 refill address of line 0", last_rd_addr, 0);
        check(rd == 8'h5A, "R7 data returned after writeback", rd, 8'h5A);

        // R8 write to line 12 while it sits in the side store
        rf0 = refills;
        do_req(1'b1, 24, 8'h33, rd, lat);
        check(lat == 2, "R8 write via swap latency", lat, 2);
        check(refills == rf0, "R8 no refill for side-store write", refills - rf0, 0);
        do_req(1'b0, 24, 0, rd, lat);
        check(lat == 1, "R8 following read is main hit", lat, 1);
        check(rd == 8'h33, "R8 written value read back", rd, 8'h33);

        // R7 random sweep over 4 tags x 4 sets x 2 words
        for (int i = 0; i < 400; i++) begin
            int a, d;
            logic wr;
            a  = int'($urandom_range(0, 31));
            wr = 1'($urandom_range(0, 2) == 0);
            d  = int'($urandom_range(0, 255));
            if (wr) begin
                do_req(1'b1, a, d, rd, lat);
                check(rd == d, "R7 write response", rd, d);
            end else begin
                do_req(1'b0, a, 0, rd, lat);
                check(rd == int'(ref_mem[a]), "R7 read matches last write", rd, int'(ref_mem[a]));
            end
            check(lat >= 1 && lat < 200, "R9 request completes", lat, 1);
        end

        done = 1'b1;
    end

    initial begin
        while (!done && cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        end
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule